// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit nanosecond time value. On each clock while it is enabled, a raw counter advances by a whole-nanosecond step taken from the control word. A 32-bit fractional addend is summed into a 32-bit accumulator on the same clock, and each carry out of that accumulator adds one more nanosecond to that clock's step. The nominal rate is therefore the fixed-point value step.addend nanoseconds per clock: whole nanoseconds in the upper 32 bits, fraction in the lower 32.

The reported time is the raw counter plus a 64-bit offset register. Software can shift time by rewriting the offset while the raw counter keeps running. It can also load the raw counter directly. That load is a two-step write: the low half is staged first, and the write of the high half commits the full 64-bit value in one edge.

A read-coherence state machine has two states. `RD_LIVE` is the reset state. A read of the low half of current time moves it to `RD_HELD` (transition *snap*) and latches the high half at that edge. A read of the high half moves it back to `RD_LIVE` (transition *release*). In `RD_HELD` the high-half read returns the latched value. In `RD_LIVE` it returns the live high half.

Top module: `tod_counter`

## Requirements
- R1: After reset, the control word, the addend, the offset, the raw counter and current time all read zero, and the read state machine is in `RD_LIVE`.
- R2: The control word has an enable bit at bit 2 and a 10-bit whole-nanosecond step at bits 25:16. It reads back with every other bit zero.
- R3: While the enable bit is clear and no counter load takes place, the raw counter does not change.
- R4: While enabled, each clock adds the step plus the carry out of `acc + addend` (32 bits) to the raw counter. After n enabled clocks from a load, the counter equals load + n·step + floor(n·addend / 2^32).
- R5: The raw counter and current time wrap modulo 2^64.
- R6: A write to the raw-low address (4) only stages data and leaves the counter unchanged. A write to the raw-high address (5) loads {data, staged low} at that edge, clears the accumulator and overrides that clock's increment.
- R7: Current time equals the raw counter plus the offset, modulo 2^64. The offset halves sit at addresses 2 (low) and 3 (high). Writing the offset does not change the raw counter.
- R8: A read of current-time low (address 6) latches the high half of current time at that edge. A later read of current-time high (address 7) returns the latched value even though the counter has advanced since.
- R9: A read of current-time high that is not preceded by a low read since the last high read returns the live high half.
- R10: The address map is: 0 control, 1 addend, 2/3 offset, 4/5 raw counter, 6/7 current time. Read data is valid combinationally in the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cur_time | output | 64 | Current time (raw counter plus offset) |

## Verification
The assertions check on every cycle that the counter stays put while it is disabled and that each enabled step is the programmed step or one more. They also check that a high-half load commits the staged value and clears the accumulator, that a low read captures the high half, and that a high read releases the hold. The bench scenarios are needed to show the long-run fractional rate against the closed-form n·step + floor(n·addend/2^32), the wrap past 2^64, that the offset leaves the raw count untouched, and that a latched high half stays coherent while the counter keeps moving.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int REG_AW  = 3;
    localparam int EN_BIT  = 2;
    localparam int PER_LSB = 16;
    localparam int PER_W   = 10;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL   = 3'd0,
        RA_ADDEND = 3'd1,
        RA_OFS_LO = 3'd2,
        RA_OFS_HI = 3'd3,
        RA_CNT_LO = 3'd4,
        RA_CNT_HI = 3'd5,
        RA_NOW_LO = 3'd6,
        RA_NOW_HI = 3'd7
    } reg_addr_e;

    typedef enum logic {
        RD_LIVE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
    import tod_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              en,
    output logic [PER_W-1:0]  period,
    output logic [DW-1:0]     addend,
    output logic [TW-1:0]     offset,
    output logic              load,
    output logic [TW-1:0]     load_val
);
    localparam int HALVES = TW / DW;

    logic [DW-1:0] staged_lo;
    reg_addr_e     wa;

    assign wa       = reg_addr_e'(addr);
    assign load     = wr && (wa == RA_CNT_HI);
    assign load_val = {wdata, staged_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            period    <= '0;
            addend    <= '0;
            staged_lo <= '0;
        end else if (wr) begin
            if (wa == RA_CTRL) begin
                en     <= wdata[EN_BIT];
                period <= wdata[PER_LSB +: PER_W];
            end
            if (wa == RA_ADDEND) addend    <= wdata;
            if (wa == RA_CNT_LO) staged_lo <= wdata;
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_ofs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                offset[h*DW +: DW] <= '0;
            else if (wr && (wa == reg_addr_e'(32'(RA_OFS_LO) + h)))
                offset[h*DW +: DW] <= wdata;
        end
    end
endmodule

// File: rtl/tod_step_engine.sv
module tod_step_engine
    import tod_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic [DW-1:0]    addend,
    input  logic             load,
    input  logic [TW-1:0]    load_val,
    output logic [TW-1:0]    cnt_q
);
    logic [DW-1:0] acc_q;
    logic [DW-1:0] acc_sum;
    logic          carry;
    logic [TW-1:0] step;

    always_comb begin
        {carry, acc_sum} = {1'b0, acc_q} + {1'b0, addend};
        step = TW'(period) + TW'(carry);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            acc_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + step;
            acc_q <= acc_sum;
        end
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt_q)); // R3

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> (((cnt_q - $past(cnt_q)) == TW'($past(period))) ||
                           ((cnt_q - $past(cnt_q)) == TW'($past(period)) + TW'(1)))); // R4

    AST_LOAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((cnt_q == $past(load_val)) && (acc_q == '0))); // R6
endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
    import tod_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  logic              en,
    input  logic [PER_W-1:0]  period,
    input  logic [DW-1:0]     addend,
    input  logic [TW-1:0]     offset,
    input  logic [TW-1:0]     cnt,
    input  logic [TW-1:0]     cur,
    output logic [DW-1:0]     rdata
);
    rd_state_e     state_q, state_d;
    logic [DW-1:0] snap_q;
    logic [DW-1:0] ctrl_word;
    reg_addr_e     ra;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rd) begin
            if (ra == RA_NOW_LO)      state_d = RD_HELD;
            else if (ra == RA_NOW_HI) state_d = RD_LIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        snap_q <= '0;
        else if (rd && (ra == RA_NOW_LO))  snap_q <= cur[TW-1:DW];
    end

    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[EN_BIT]            = en;
        ctrl_word[PER_LSB +: PER_W]  = period;
        unique case (ra)
            RA_CTRL:   rdata = ctrl_word;
            RA_ADDEND: rdata = addend;
            RA_OFS_LO: rdata = offset[DW-1:0];
            RA_OFS_HI: rdata = offset[TW-1:DW];
            RA_CNT_LO: rdata = cnt[DW-1:0];
            RA_CNT_HI: rdata = cnt[TW-1:DW];
            RA_NOW_LO: rdata = cur[DW-1:0];
            RA_NOW_HI: rdata = (state_q == RD_HELD) ? snap_q : cur[TW-1:DW];
            default:   rdata = '0;
        endcase
    end

    AST_SNAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ra == RA_NOW_LO)) |=> ((snap_q == $past(cur[TW-1:DW])) && (state_q == RD_HELD))); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ra == RA_NOW_HI)) |=> (state_q == RD_LIVE)); // R9
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [TW-1:0]     cur_time
);
    logic             en;
    logic [PER_W-1:0] period;
    logic [DW-1:0]    addend;
    logic [TW-1:0]    offset;
    logic             load;
    logic [TW-1:0]    load_val;
    logic [TW-1:0]    cnt;

    tod_cfg_regs #(.DW(DW), .TW(TW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .en(en), .period(period), .addend(addend), .offset(offset),
        .load(load), .load_val(load_val)
    );

    tod_step_engine #(.DW(DW), .TW(TW)) u_step (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period), .addend(addend),
        .load(load), .load_val(load_val), .cnt_q(cnt)
    );

    assign cur_time = cnt + offset;

    tod_read_port #(.DW(DW), .TW(TW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr), .en(en),
        .period(period), .addend(addend), .offset(offset), .cnt(cnt),
        .cur(cur_time), .rdata(reg_rdata)
    );
endmodule

// File: tb/tod_counter_test.sv
module tod_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] cur_time;

    int checks = 0;
    int errors = 0;
    longint unsigned edges = 0;

    // bench model state
    logic [63:0] m_base = '0;
    logic [63:0] m_ofs = '0;
    logic [31:0] m_add = '0;
    logic [9:0]  m_per = '0;
    logic        m_en = 1'b0;
    longint unsigned m_frozen = 0;
    longint unsigned m_en_edge = 0;
    longint unsigned last_edge = 0;

    tod_counter uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cur_time(cur_time)
    );

    always #2 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    function automatic logic [63:0] raw_after(longint unsigned n);
        logic [63:0] nn;
        nn = 64'(n);
        return m_base + nn * 64'(m_per) + ((nn * 64'(m_add)) >> 32);
    endfunction

    function automatic logic [63:0] raw_now();
        longint unsigned n;
        n = m_frozen + (m_en ? (edges - m_en_edge) : 0);
        return raw_after(n);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        last_edge = edges;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic [63:0] raw_exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        raw_exp = raw_now();
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input bit e, input logic [9:0] p);
        wr(3'd0, (32'(p) << 16) | (32'(e) << 2));
        if (m_en && !e) m_frozen = m_frozen + (last_edge - m_en_edge);
        if (!m_en && e) m_en_edge = last_edge;
        m_en = e; m_per = p;
    endtask

    // disable, set addend/offset, load counter; leaves counter stopped
    task automatic setup(input logic [63:0] base, input logic [31:0] a, input logic [63:0] ofs, input logic [9:0] p);
        set_ctrl(1'b0, p);
        wr(3'd1, a);
        wr(3'd2, ofs[31:0]);
        wr(3'd3, ofs[63:32]);
        wr(3'd4, base[31:0]);
        wr(3'd5, base[63:32]);
        m_base = base; m_add = a; m_ofs = ofs; m_frozen = 0;
    endtask

    task automatic coherent_read(input string req);
        logic [31:0] lo, hi;
        logic [63:0] e0, e1;
        rd(3'd6, lo, e0);
        idle(3);
        rd(3'd7, hi, e1);
        chk(lo == 32'(e0 + m_ofs), req, {32'd0, lo}, {32'd0, 32'(e0 + m_ofs)});
        chk(hi == (e0 + m_ofs) >> 32, req, {32'd0, hi}, (e0 + m_ofs) >> 32);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d, d2;
        logic [63:0] e, e2;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(3'd0, d, e); chk(d == 0, "R1 ctrl", {32'd0, d}, 0);
        rd(3'd6, d, e); chk(d == 0, "R1 now_lo", {32'd0, d}, 0);
        rd(3'd7, d, e); chk(d == 0, "R1 now_hi", {32'd0, d}, 0);
        rd(3'd5, d, e); chk(d == 0, "R1 cnt_hi", {32'd0, d}, 0);

        // R2 control readback masks undefined bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d, e); chk(d == 32'h03FF_0004, "R2 ctrl readback", {32'd0, d}, 64'h03FF_0004);
        wr(3'd0, 32'h0);

        // R4 directed half-ns fraction: 8.5 ns per clock
        setup(64'd100, 32'h8000_0000, 64'd0, 10'd8);
        set_ctrl(1'b1, 10'd8);
        idle(37);
        rd(3'd4, d, e); chk(d == e[31:0], "R4 half fraction", {32'd0, d}, e);
        coherent_read("R4 coherent");

        // R3 hold while disabled
        set_ctrl(1'b0, 10'd8);
        rd(3'd4, d, e);
        idle(6);
        rd(3'd4, d2, e2);
        chk(d == d2, "R3 hold", {32'd0, d2}, {32'd0, d});
        chk(d2 == e2[31:0], "R3 value", {32'd0, d2}, e2);

        // R6 staging low half alone changes nothing
        wr(3'd4, 32'hDEAD_BEEF);
        rd(3'd4, d, e); chk(d == e[31:0], "R6 staged only", {32'd0, d}, e);

        // R5 wrap modulo 2^64 with offset
        setup(64'hFFFF_FFFF_FFFF_FFE0, 32'h4000_0000, 64'h10, 10'd7);
        set_ctrl(1'b1, 10'd7);
        idle(9);
        coherent_read("R5 wrap");
        rd(3'd5, d, e); chk(d == e[63:32], "R5 raw high", {32'd0, d}, e >> 32);

        // R10 readback of configuration
        rd(3'd1, d, e); chk(d == 32'h4000_0000, "R10 addend", {32'd0, d}, 64'h4000_0000);
        rd(3'd2, d, e); chk(d == 32'h10, "R10 ofs_lo", {32'd0, d}, 64'h10);

        // R7 offset write while running leaves raw count alone
        wr(3'd3, 32'h0000_0100); m_ofs = {32'h100, 32'h10};
        rd(3'd4, d, e); chk(d == e[31:0], "R7 raw unchanged", {32'd0, d}, e);
        rd(3'd7, d, e); chk(d == 32'((e + m_ofs) >> 32), "R7 R9 live high", {32'd0, d}, (e + m_ofs) >> 32);

        // random scenarios
        for (int i = 0; i < 24; i++) begin
            logic [63:0] base, ofs;
            logic [31:0] a;
            logic [9:0] p;
            base = {$urandom, $urandom};
            ofs  = {$urandom, $urandom};
            a    = $urandom;
            p    = 10'(($urandom % 1023) + 1);
            setup(base, a, ofs, p);
            set_ctrl(1'b1, p);
            idle(int'($urandom % 60) + 5);
            coherent_read("R8 R7 R4 random");
            rd(3'd4, d, e); chk(d == e[31:0], "R4 raw random", {32'd0, d}, e);
            rd(3'd7, d, e); chk(d == 32'((e + m_ofs) >> 32), "R9 live random", {32'd0, d}, (e + m_ofs) >> 32);
            chk(cur_time == raw_now() + m_ofs, "R7 cur_time port", cur_time, raw_now() + m_ofs);
        end

        // R6 load overrides increment while running
        set_ctrl(1'b1, 10'd5);
        wr(3'd4, 32'h1234_5678);
        wr(3'd5, 32'h0000_0042);
        m_base = 64'h0000_0042_1234_5678; m_frozen = 0; m_en_edge = last_edge; m_add = m_add;
        idle(4);
        rd(3'd4, d, e); chk(d == e[31:0], "R6 load while running", {32'd0, d}, e);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule